// File: doc/BRIEF.md
# Offset Register Sequencer

This block holds the two threshold offsets used by a dual-clock FIFO's flag logic. One offset sets how close to empty the almost-empty flag works; the other sets how close to full the almost-full flag works. While the active-low load input is held low, the FIFO's own data input and write enable program these offsets, and the read enable reads them back through a readback data port. No extra address lines are needed. When load is high, the write and read enables pass through to the FIFO array as ordinary push and pop qualifiers.

A single load strobe serves both offsets. A write-side selector alternates between them on each programming write, and it keeps its position when load goes high, so a later session continues where the last one stopped. A second selector in the read clock domain steps through the offsets on readback and moves independently of the write side. Both offsets are passed to the flag comparators at the FIFO address width.

Top module: `ofs_seq`

## Requirements
- R1: A synchronous active-high reset loads both offsets with the default for the configured depth and points both selectors at the empty offset. After reset, rb_data is zero and rb_valid is low.
- R2: A programming write (wr_clk rising edge with ld_n=0 and wr_en_n=0) stores wr_data[11:0] into the selected 12-bit offset. wr_data bits above 11 are ignored.
- R3: Successive programming writes alternate targets: empty offset first, then full offset, then back to the empty offset.
- R4: A wr_clk edge with ld_n=0 and wr_en_n=1 changes neither offset and does not move the write selector.
- R5: The write selector keeps its position while ld_n is high, including across normal FIFO writes. The next programming session continues with the next offset in sequence.
- R6: A readback (rd_clk rising edge with ld_n=0 and rd_en_n=0) loads rb_data with the offset at the read selector, zero in bits 17:12. It sets rb_sel to that offset's code (0 = empty offset, 1 = full offset), raises rb_valid for the next cycle, and moves the read selector to the other offset.
- R7: The read selector moves only on readbacks and the write selector moves only on programming writes.
- R8: rb_data and rb_sel hold their value in every rd_clk cycle without a readback.
- R9: empty_ofs and full_ofs carry the stored 12-bit offsets at the FIFO address width log2(DEPTH). They are truncated to the low bits when that width is below 12 and zero-extended when it is above 12.
- R10: fifo_wr_ok is high exactly when ld_n=1 and wr_en_n=0. fifo_rd_ok is high exactly when ld_n=1 and rd_en_n=0.
- R11: The reset default is 31 for depth 256, 63 for depth 512 and 127 for any other depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | FIFO input data; bits 11:0 carry offsets |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_n | input | 1 | Active-low read enable |
| ld_n | input | 1 | Active-low offset access select |
| empty_ofs | output | log2(DEPTH) | Almost-empty offset to the flag logic |
| full_ofs | output | log2(DEPTH) | Almost-full offset to the flag logic |
| fifo_wr_ok | output | 1 | Qualified push to the FIFO array |
| fifo_rd_ok | output | 1 | Qualified pop from the FIFO array |
| rb_data | output | DATA_W | Offset readback data |
| rb_sel | output | 1 | Offset shown on rb_data (0 empty, 1 full) |
| rb_valid | output | 1 | rb_data was loaded on the last rd_clk edge |

## Verification
The hardest case to reach is the two selectors sitting at different offsets. The stimulus ends a programming session after an odd number of writes and then runs a normal FIFO write with load high. It then reads back once and programs again, so the write side targets the empty offset while the read side targets the full offset. A later readback must return the full offset and leave the fresh empty value for the read after it. A second instance at depth 1024 covers the other reset default and the wider truncation.

// File: rtl/ofsq_pkg.sv
package ofsq_pkg;

    localparam int OFS_W = 12;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic [OFS_W-1:0] empty_ofs;
        logic [OFS_W-1:0] full_ofs;
    } ofs_pair_t;

    function automatic logic [OFS_W-1:0] default_ofs(input int depth);
        if (depth == 256)      return OFS_W'(31);
        else if (depth == 512) return OFS_W'(63);
        else                   return OFS_W'(127);
    endfunction

    function automatic ofs_sel_e next_sel(input ofs_sel_e s);
        return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

    function automatic logic [OFS_W-1:0] pick(input ofs_pair_t p, input ofs_sel_e s);
        return (s == SEL_EMPTY) ? p.empty_ofs : p.full_ofs;
    endfunction

endpackage

// File: rtl/ofsq_wr_seq.sv
module ofsq_wr_seq
    import ofsq_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] data,
    output ofs_pair_t         regs,
    output ofs_sel_e          ptr
);
    localparam logic [OFS_W-1:0] DEF_OFS = default_ofs(DEPTH);

    logic             prog;
    logic [OFS_W-1:0] new_val;
    logic             unused_upper;

    assign prog         = ~ld_n & ~wen_n;
    assign new_val      = data[OFS_W-1:0];
    assign unused_upper = ^data[DATA_W-1:OFS_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.empty_ofs <= DEF_OFS;
            regs.full_ofs  <= DEF_OFS;
            ptr            <= SEL_EMPTY;
        end else if (prog) begin
            if (ptr == SEL_EMPTY) regs.empty_ofs <= new_val;
            else                  regs.full_ofs  <= new_val;
            ptr <= next_sel(ptr);
        end
    end

endmodule

// File: rtl/ofsq_rd_seq.sv
module ofsq_rd_seq
    import ofsq_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              ren_n,
    input  ofs_pair_t         regs,
    output logic [DATA_W-1:0] rb_data,
    output ofs_sel_e          rb_sel,
    output logic              rb_valid,
    output ofs_sel_e          ptr
);
    logic fetch;
    assign fetch = ~ld_n & ~ren_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_data  <= '0;
            rb_sel   <= SEL_EMPTY;
            rb_valid <= 1'b0;
            ptr      <= SEL_EMPTY;
        end else begin
            rb_valid <= fetch;
            if (fetch) begin
                rb_data <= DATA_W'(pick(regs, ptr));
                rb_sel  <= ptr;
                ptr     <= next_sel(ptr);
            end
        end
    end

endmodule

// File: rtl/ofsq_fit.sv
module ofsq_fit #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    generate
        if (OUT_W <= IN_W) begin : g_trunc
            logic unused_drop;
            assign dout = din[OUT_W-1:0];
            if (OUT_W < IN_W) begin : g_drop
                assign unused_drop = ^din[IN_W-1:OUT_W];
            end else begin : g_none
                assign unused_drop = 1'b0;
            end
        end else begin : g_ext
            assign dout = {{(OUT_W-IN_W){1'b0}}, din};
        end
    endgenerate
endmodule

// File: rtl/ofs_seq.sv
module ofs_seq
    import ofsq_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 18,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en_n,
    input  logic              ld_n,
    output logic [ADDR_W-1:0] empty_ofs,
    output logic [ADDR_W-1:0] full_ofs,
    output logic              fifo_wr_ok,
    output logic              fifo_rd_ok,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_sel,
    output logic              rb_valid
);
    ofs_pair_t regs;
    ofs_sel_e  w_ptr;
    ofs_sel_e  r_ptr;
    ofs_sel_e  rb_sel_e;

    assign fifo_wr_ok = ld_n & ~wr_en_n;
    assign fifo_rd_ok = ld_n & ~rd_en_n;
    assign rb_sel     = rb_sel_e;

    ofsq_wr_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_wr (
        .clk   (wr_clk),
        .rst   (wr_rst),
        .ld_n  (ld_n),
        .wen_n (wr_en_n),
        .data  (wr_data),
        .regs  (regs),
        .ptr   (w_ptr)
    );

    ofsq_rd_seq #(.DATA_W(DATA_W)) u_rd (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .ld_n     (ld_n),
        .ren_n    (rd_en_n),
        .regs     (regs),
        .rb_data  (rb_data),
        .rb_sel   (rb_sel_e),
        .rb_valid (rb_valid),
        .ptr      (r_ptr)
    );

    ofsq_fit #(.IN_W(OFS_W), .OUT_W(ADDR_W)) u_fit_e (
        .din  (regs.empty_ofs),
        .dout (empty_ofs)
    );

    ofsq_fit #(.IN_W(OFS_W), .OUT_W(ADDR_W)) u_fit_f (
        .din  (regs.full_ofs),
        .dout (full_ofs)
    );

endmodule

// File: rtl/ofs_seq_chk.sv
module ofs_seq_chk #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 18,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CMP_W  = (ADDR_W < 12) ? ADDR_W : 12
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_en_n,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en_n,
    input logic              ld_n,
    input logic [ADDR_W-1:0] empty_ofs,
    input logic [ADDR_W-1:0] full_ofs,
    input logic [DATA_W-1:0] rb_data,
    input logic              rb_valid,
    input logic              w_ptr,
    input logic              r_ptr
);
    // R4
    p_idle_hold_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!ld_n && wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(w_ptr)));

    // R3
    p_wr_step_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!ld_n && !wr_en_n) |=> (w_ptr != $past(w_ptr)));

    // R2
    p_empty_load_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!ld_n && !wr_en_n && !w_ptr) |=> (empty_ofs[CMP_W-1:0] == $past(wr_data[CMP_W-1:0])));

    // R5
    p_ptr_keep_r5: assert property (@(posedge wr_clk) disable iff (wr_rst)
        ld_n |=> $stable(w_ptr));

    // R6
    p_rd_step_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!ld_n && !rd_en_n) |=> (rb_valid && r_ptr != $past(r_ptr)));

    // R8
    p_rb_hold_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (ld_n || rd_en_n) |=> ($stable(rb_data) && !rb_valid));

    // R7
    p_rd_ptr_indep_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (ld_n || rd_en_n) |=> $stable(r_ptr));

endmodule

bind ofs_seq ofs_seq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .wr_clk    (wr_clk),
    .wr_rst    (wr_rst),
    .wr_en_n   (wr_en_n),
    .wr_data   (wr_data),
    .rd_clk    (rd_clk),
    .rd_rst    (rd_rst),
    .rd_en_n   (rd_en_n),
    .ld_n      (ld_n),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .rb_data   (rb_data),
    .rb_valid  (rb_valid),
    .w_ptr     (w_ptr),
    .r_ptr     (r_ptr)
);

// File: tb/ofs_seq_tb.sv
module ofs_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en_n = 1'b1;
    logic        rd_en_n = 1'b1;
    logic        ld_n = 1'b1;
    logic [17:0] wr_data = '0;

    logic [7:0]  e8, f8;
    logic [9:0]  e10, f10;
    logic        wok, rok, wok_k, rok_k;
    logic [17:0] rb, rb_k;
    logic        rsel, rval, rsel_k, rval_k;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [17:0] exp_q[$];

    always #10 clk = ~clk;

    ofs_seq #(.DEPTH(256), .DATA_W(18)) u_dut (
        .wr_clk(clk), .wr_rst(rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_clk(clk), .rd_rst(rst), .rd_en_n(rd_en_n), .ld_n(ld_n),
        .empty_ofs(e8), .full_ofs(f8), .fifo_wr_ok(wok), .fifo_rd_ok(rok),
        .rb_data(rb), .rb_sel(rsel), .rb_valid(rval)
    );

    ofs_seq #(.DEPTH(1024), .DATA_W(18)) u_dut_k (
        .wr_clk(clk), .wr_rst(rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_clk(clk), .rd_rst(rst), .rd_en_n(rd_en_n), .ld_n(ld_n),
        .empty_ofs(e10), .full_ofs(f10), .fifo_wr_ok(wok_k), .fifo_rd_ok(rok_k),
        .rb_data(rb_k), .rb_sel(rsel_k), .rb_valid(rval_k)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic prog(input logic [17:0] d);
        @(negedge clk);
        ld_n = 1'b0; wr_en_n = 1'b0; wr_data = d;
        @(negedge clk);
        ld_n = 1'b1; wr_en_n = 1'b1;
    endtask

    // expected value pushed as {sel, 17 bits of data}; bit 17 of data is zero by R6
    task automatic readback(input logic [11:0] v, input logic sel);
        exp_q.push_back({sel, 5'b0, v});
        @(negedge clk);
        ld_n = 1'b0; rd_en_n = 1'b0;
        @(negedge clk);
        ld_n = 1'b1; rd_en_n = 1'b1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rval) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected readback", rb, 0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                check(rb == {6'b0, e[11:0]}, "R6 rb_data", rb, {6'b0, e[11:0]});
                check(rsel == e[17], "R6 rb_sel", rsel, e[17]);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R11 reset values
        check(e8 == 8'd31 && f8 == 8'd31, "R1 defaults depth256", {e8, f8}, {8'd31, 8'd31});
        check(e10 == 10'd127 && f10 == 10'd127, "R11 defaults depth1024", {e10, f10}, {10'd127, 10'd127});
        check(rb == 18'd0 && !rval, "R1 readback reset", rb, 0);

        // R10 qualifiers
        wr_en_n = 1'b0; rd_en_n = 1'b0; #1;
        check(wok && rok, "R10 normal access", {wok, rok}, 3);
        ld_n = 1'b0; #1;
        check(!wok && !rok, "R10 load blocks fifo", {wok, rok}, 0);
        ld_n = 1'b1; rd_en_n = 1'b1; #1;
        check(wok && !rok, "R10 write only", {wok, rok}, 2);
        wr_en_n = 1'b1;

        // R2 / R9: first programming write hits empty offset, upper bits ignored
        prog(18'h3F1C3);
        check(e8 == 8'hC3, "R9 truncate empty", e8, 8'hC3);
        check(e10 == 10'h1C3, "R2 empty offset wide", e10, 10'h1C3);
        check(f8 == 8'd31, "R2 full untouched", f8, 31);

        // R4: load low, write enable high
        @(negedge clk);
        ld_n = 1'b0; wr_en_n = 1'b1; wr_data = 18'h00AAA;
        repeat (2) @(negedge clk);
        ld_n = 1'b1;
        check(e8 == 8'hC3 && f8 == 8'd31, "R4 idle no write", {e8, f8}, {8'hC3, 8'd31});

        // R3 second and third writes
        prog(18'h00042);
        check(f8 == 8'h42 && e8 == 8'hC3, "R3 second write to full", {e8, f8}, {8'hC3, 8'h42});
        prog(18'h00011);
        check(e8 == 8'h11 && f8 == 8'h42, "R3 third write wraps", {e8, f8}, {8'h11, 8'h42});

        // R5: normal FIFO write with load high, then new session
        @(negedge clk);
        wr_en_n = 1'b0; wr_data = 18'h00999;
        @(negedge clk);
        wr_en_n = 1'b1;
        check(e8 == 8'h11 && f8 == 8'h42, "R5 normal write leaves offsets", {e8, f8}, {8'h11, 8'h42});
        prog(18'h00077);
        check(f8 == 8'h77 && e8 == 8'h11, "R5 session continues at full", {e8, f8}, {8'h11, 8'h77});

        // R6 readback sequence from empty offset
        readback(12'h011, 1'b0);
        readback(12'h077, 1'b1);
        readback(12'h011, 1'b0);

        // R8 hold
        repeat (2) @(negedge clk);
        check(rb == 18'h00011 && rsel == 1'b0, "R8 readback held", rb, 18'h00011);

        // R7: write side at empty, read side at full
        prog(18'h00222);
        check(e10 == 10'h222, "R7 write side at empty", e10, 10'h222);
        readback(12'h077, 1'b1);
        readback(12'h222, 1'b0);

        // R1 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(e8 == 8'd31 && f8 == 8'd31 && rb == 0, "R1 reset restores", {e8, f8}, {8'd31, 8'd31});
        prog(18'h00055);
        check(e8 == 8'h55 && f8 == 8'd31, "R1 pointer back at empty", {e8, f8}, {8'h55, 8'd31});
        readback(12'h055, 1'b0);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6 all readbacks seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule